// File: doc/BRIEF.md
# Vertically doubled image scan-out window

This block sits beside a video sync generator and works out, line by line, whether a stored monochrome picture should appear on the current video line and which picture row that line should show. On every line-start strobe it takes the interlaced frame line number and folds it onto a line index within the current field. It then tests that index against a fixed vertical window whose height is twice the picture height.

Each picture row is shown on two consecutive qualifying lines, so the picture is stretched vertically. For a line inside the window, the block waits a fixed number of clock cycles after the line-start strobe. It then emits a one-cycle start pulse together with the base address of the row to fetch, for a pixel shifter that reads a simple ROM-like store. The row address steps one row width after each pair of lines and wraps to zero past the last row. A vertical-interval strobe puts the sequence back to row 0.

Top module: `vwin_scan`

## Requirements
- R1: The field line index is the line number minus FIELD_LINES (default 312) when the line number exceeds FIELD_LINES, and the line number unchanged otherwise.
- R2: A line is inside the window exactly when its field line index is strictly greater than WIN_TOP (default 118) and strictly less than WIN_TOP + REPEAT*IMG_H (REPEAT defaults to 2). `win_o` becomes 1 for such a line and 0 for any other line, in the cycle after the strobe is sampled, and holds until the next line strobe or vertical strobe.
- R3: For an in-window line whose strobe is sampled at clock edge k, `start_o` is 1 for exactly one cycle, following edge k + DELAY_CYC.
- R4: A line outside the window produces no `start_o` pulse.
- R5: While `start_o` is 1, `row_base_o` carries the row base address. Each row base is shown on REPEAT consecutive start pulses, and then the address advances by ROW_W.
- R6: When the row shown is the last one (base IMG_H*ROW_W - ROW_W), the next advance wraps the address to 0 instead of going past IMG_H*ROW_W - 1.
- R7: A vertical strobe (`vblank_i` = 1) resets the row address to 0 and the repeat count to its start, so the next two in-window lines both show row 0. It also drives `win_o` to 0.
- R8: A vertical strobe, or a new line strobe for an out-of-window line, that arrives while a start is still pending cancels that start. No `start_o` follows.
- R9: After reset, `win_o` and `start_o` are 0 and `row_base_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb_i | input | 1 | One-cycle strobe at the start of a line's active region |
| line_num_i | input | LINE_W | Frame line number, valid with `line_stb_i` |
| vblank_i | input | 1 | One-cycle strobe marking the vertical interval |
| win_o | output | 1 | Current line lies inside the picture window |
| start_o | output | 1 | One-cycle start pulse for the pixel shifter |
| row_base_o | output | ADDR_W | Base address of the row to scan out, where ADDR_W = clog2(IMG_H*ROW_W) |

## Verification
The bench builds the block with IMG_H = 4, ROW_W = 8 and DELAY_CYC = 5, and keeps the default fold point and window top. This leaves seven qualifying lines per field, so an odd window that ends partway through a row pair is exercised. It sweeps every line number from 0 to 639 with no vertical strobe in between. The carried-over state then reaches the last row and wraps to 0 within the second field, and line numbers around 312 test the fold. Directed sequences place vertical strobes in the middle of a row pair and between a strobe and its pending start.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  // Number of field lines covered by the window for a picture of h rows
  // shown rep times each.
  function automatic int span_lines(input int h, input int rep);
    return h * rep;
  endfunction

  function automatic int addr_bits(input int npix);
    return (npix > 1) ? $clog2(npix) : 1;
  endfunction
endpackage

// File: rtl/vwin_line_fold.sv
module vwin_line_fold
  import vwin_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int FIELD_LINES = 312,
  parameter int WIN_TOP     = 118,
  parameter int IMG_H       = 64,
  parameter int REPEAT      = 2,
  localparam int WIN_END    = WIN_TOP + span_lines(IMG_H, REPEAT)
) (
  input  logic [LINE_W-1:0] line_num_i,
  output logic [LINE_W-1:0] fidx_o,
  output logic              in_win_o
);
  always_comb begin
    if (line_num_i > LINE_W'(FIELD_LINES))
      fidx_o = line_num_i - LINE_W'(FIELD_LINES);
    else
      fidx_o = line_num_i;
    in_win_o = (fidx_o > LINE_W'(WIN_TOP)) && (fidx_o < LINE_W'(WIN_END));
  end
endmodule

// File: rtl/vwin_launch_timer.sv
module vwin_launch_timer #(
  parameter int DELAY_CYC = 240,
  localparam int CW       = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic cancel_i,
  output logic due_o
);
  logic [CW-1:0] cnt_q;
  logic          pend_q;

  // A fresh arm or a cancel in the same cycle overrides a due launch.
  always_comb due_o = pend_q && (cnt_q == '0) && !arm_i && !cancel_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm_i) begin
      pend_q <= 1'b1;
      cnt_q  <= CW'(DELAY_CYC - 1);
    end else if (cancel_i) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/vwin_row_seq.sv
module vwin_row_seq
  import vwin_pkg::*;
#(
  parameter int IMG_H    = 64,
  parameter int ROW_W    = 32,
  parameter int REPEAT   = 2,
  localparam int NPIX    = IMG_H * ROW_W,
  localparam int AW      = addr_bits(NPIX),
  localparam int LAST_BASE = NPIX - ROW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic          adv;

  assign addr_o = addr_q;

  generate
    if (REPEAT > 1) begin : g_rep
      localparam int RW = $clog2(REPEAT);
      logic [RW-1:0] rep_q;
      assign adv = step_i && (rep_q == RW'(REPEAT - 1));
      always_ff @(posedge clk) begin
        if (rst || clear_i)  rep_q <= '0;
        else if (adv)        rep_q <= '0;
        else if (step_i)     rep_q <= rep_q + 1'b1;
      end
    end else begin : g_norep
      assign adv = step_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear_i)
      addr_q <= '0;
    else if (adv)
      addr_q <= (addr_q == AW'(LAST_BASE)) ? '0 : addr_q + AW'(ROW_W);
  end
endmodule

// File: rtl/vwin_scan.sv
module vwin_scan
  import vwin_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int FIELD_LINES = 312,
  parameter int WIN_TOP     = 118,
  parameter int IMG_H       = 64,
  parameter int ROW_W       = 32,
  parameter int REPEAT      = 2,
  parameter int DELAY_CYC   = 240,
  localparam int ADDR_W     = addr_bits(IMG_H * ROW_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_stb_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              vblank_i,
  output logic              win_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] row_base_o
);
  logic [LINE_W-1:0] fidx;
  logic              in_win;
  logic              arm, cancel, due;
  logic [ADDR_W-1:0] addr;

  vwin_line_fold #(
    .LINE_W(LINE_W), .FIELD_LINES(FIELD_LINES), .WIN_TOP(WIN_TOP),
    .IMG_H(IMG_H), .REPEAT(REPEAT)
  ) u_fold (
    .line_num_i(line_num_i),
    .fidx_o    (fidx),
    .in_win_o  (in_win)
  );

  assign arm    = line_stb_i && in_win && !vblank_i;
  assign cancel = vblank_i || (line_stb_i && !in_win);

  vwin_launch_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .arm_i   (arm),
    .cancel_i(cancel),
    .due_o   (due)
  );

  vwin_row_seq #(.IMG_H(IMG_H), .ROW_W(ROW_W), .REPEAT(REPEAT)) u_rows (
    .clk    (clk),
    .rst    (rst),
    .clear_i(vblank_i),
    .step_i (due),
    .addr_o (addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_o      <= 1'b0;
      start_o    <= 1'b0;
      row_base_o <= '0;
    end else begin
      if (vblank_i)        win_o <= 1'b0;
      else if (line_stb_i) win_o <= in_win;
      start_o <= due;
      if (due) row_base_o <= addr;
    end
  end

  logic unused_fidx;
  assign unused_fidx = ^fidx;
endmodule

// File: rtl/vwin_scan_chk.sv
module vwin_scan_chk #(
  parameter int ROW_W = 32,
  parameter int NPIX  = 2048,
  parameter int AW    = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          vblank_i,
  input logic          win_o,
  input logic          start_o,
  input logic [AW-1:0] row_base_o
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R3

  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    start_o |-> win_o); // R4

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ((row_base_o % AW'(ROW_W)) == '0)); // R5

  AST_BASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (row_base_o <= AW'(NPIX - ROW_W))); // R6

  AST_VBLANK_CLOSES: assert property (@(posedge clk) disable iff (rst)
    vblank_i |=> (!win_o && !start_o)); // R7
endmodule

bind vwin_scan vwin_scan_chk #(
  .ROW_W(ROW_W), .NPIX(IMG_H * ROW_W), .AW(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .vblank_i(vblank_i), .win_o(win_o),
  .start_o(start_o), .row_base_o(row_base_o)
);

// File: tb/sim_vwin_scan.sv
module sim_vwin_scan;
  localparam int CLK_PERIOD = 10;
  localparam int LW  = 10;
  localparam int H   = 4;
  localparam int W   = 8;
  localparam int D   = 5;
  localparam int REP = 2;
  localparam int AW  = $clog2(H * W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_stb = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic          vblank = 1'b0;
  logic          win;
  logic          start;
  logic [AW-1:0] row_base;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int exp_addr = 0;
  int exp_rep = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vwin_scan #(
    .LINE_W(LW), .IMG_H(H), .ROW_W(W), .REPEAT(REP), .DELAY_CYC(D)
  ) u0 (
    .clk(clk), .rst(rst), .line_stb_i(line_stb), .line_num_i(line_num),
    .vblank_i(vblank), .win_o(win), .start_o(start), .row_base_o(row_base)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit model_in_win(input int n);
    int f;
    f = (n > 312) ? n - 312 : n;
    return (f > 118) && (f < 118 + REP * H);
  endfunction

  task automatic model_step();
    if (exp_rep == REP - 1) begin
      exp_rep = 0;
      exp_addr = (exp_addr + W > H * W - 1) ? 0 : exp_addr + W;
    end else begin
      exp_rep++;
    end
  endtask

  // Issue one line strobe and observe the following D+2 cycles.
  task automatic do_line(input int n);
    bit ew;
    int nst, at, base;
    ew = model_in_win(n);
    nst = 0; at = -1; base = -1;
    @(negedge clk); line_stb = 1'b1; line_num = LW'(n);
    @(negedge clk); line_stb = 1'b0;
    chk(win == ew, (n > 312) ? "R1 window after fold" : "R2 window bounds", int'(win), int'(ew));
    for (int j = 0; j <= D + 2; j++) begin
      if (start) begin nst++; at = j; base = int'(row_base); end
      @(negedge clk);
    end
    if (ew) begin
      chk(nst == 1 && at == D, "R3 start timing", at, D);
      chk(base == exp_addr, "R5 R6 row base", base, exp_addr);
      model_step();
    end else begin
      chk(nst == 0, "R4 no start outside window", nst, 0);
    end
  endtask

  task automatic do_vblank();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    exp_addr = 0; exp_rep = 0;
    chk(win == 1'b0, "R7 window closed by vblank", int'(win), 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int nst;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(win == 1'b0, "R9 reset win", int'(win), 0);
    chk(start == 1'b0, "R9 reset start", int'(start), 0);
    chk(row_base == '0, "R9 reset row base", int'(row_base), 0);

    // Full sweep across two fields without vertical strobes: fold, window, wrap.
    for (int n = 0; n < 640; n++) do_line(n);

    // Vertical strobe mid-pair restarts at row 0 shown twice.
    do_vblank();
    for (int n = 119; n <= 121; n++) do_line(n);
    do_vblank();
    do_line(122); // R7 expects row 0
    do_line(123); // R7 expects row 0 again
    do_line(124); // expects row 1

    // Pending start cancelled by a vertical strobe.
    @(negedge clk); line_stb = 1'b1; line_num = LW'(120);
    @(negedge clk); line_stb = 1'b0;
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    exp_addr = 0; exp_rep = 0;
    nst = 0;
    for (int j = 0; j < D + 3; j++) begin
      if (start) nst++;
      @(negedge clk);
    end
    chk(nst == 0, "R8 vblank cancels start", nst, 0);

    // Pending start cancelled by an out-of-window line strobe.
    @(negedge clk); line_stb = 1'b1; line_num = LW'(121);
    @(negedge clk); line_num = LW'(10);
    @(negedge clk); line_stb = 1'b0;
    nst = 0;
    for (int j = 0; j < D + 3; j++) begin
      if (start) nst++;
      @(negedge clk);
    end
    chk(nst == 0, "R8 outside line cancels start", nst, 0);
    chk(win == 1'b0, "R8 window follows latest line", int'(win), 0);

    // State untouched by the cancelled launches: row 0 twice.
    do_line(119);
    do_line(120);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule